// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This execution sub-unit handles the field-manipulation instructions of a 64-bit load/store style processor. It receives the 32-bit instruction word together with the two source operands already read from the register file. The rs operand supplies the bits to extract or insert. The rt operand is the current destination value, which an insert merges into. The unit returns the value to be written back to rt. One clock later it raises a result strobe and, when needed, a flag marking the instruction as reserved.

Field position and field size (or upper bound) come from two 5-bit instruction fields. Each opcode variant adds a fixed offset of 32 to one or both of them, so fields anywhere in the 64-bit register can be reached. The word-sized variants work on the low 32 bits and sign-extend their 32-bit result. A separate input tells the unit that doubleword operations are currently not permitted.

Top module: `bitfield_unit`

## Requirements
- R1: `result`, `out_valid` and `reserved_op` are registered. `out_valid` is high in exactly the cycle after a cycle with `in_valid` high and is low otherwise. A synchronous active-high `rst` clears `out_valid` and `reserved_op`.
- R2: The decode uses only these instruction bits: [31:26] as the major opcode (must be 011111), [15:11] as the size/upper-bound field F1, [10:6] as the position field F0 and [5:0] as the function code. Bits [25:16] have no effect on the outcome.
- R3: Function 000000 takes the low 32 bits of rs and extracts bits F0 through F0+F1, with positions above 31 reading as zero. The field is right-justified with zero fill, and the 32-bit result is sign-extended from bit 31 to 64 bits.
- R4: Function 000011 extracts rs bits F0 through F0+F1, right-justified with zero fill.
- R5: Function 000001 extracts a field of F1+33 bits starting at rs bit F0, with positions above 63 reading as zero.
- R6: Function 000010 extracts a field of F1+1 bits starting at rs bit F0+32, with positions above 63 reading as zero.
- R7: Function 000100 applies when F0 <= F1. It replaces bits F0..F1 of the low word of rt with the low bits of rs and keeps the other low-word bits. The 32-bit result is then sign-extended. When F0 > F1, all 64 bits of rt are returned unchanged.
- R8: Function 000111 applies when F0 <= F1. It replaces rt bits F0..F1 with the low bits of rs and keeps all other bits. When F0 > F1, rt is returned unchanged.
- R9: Function 000101 replaces rt bits F0..F1+32 with the low bits of rs and keeps all other bits. Because F0 never exceeds F1+32, this variant always applies.
- R10: Function 000110 applies when F0 <= F1. It replaces rt bits F0+32..F1+32 with the low bits of rs and keeps all other bits. When F0 > F1, rt is returned unchanged.
- R11: A major opcode other than 011111, or a function code above 000111, sets `reserved_op` with the result and returns rt unchanged.
- R12: When `wide_disable` is high, functions 000001, 000010, 000011, 000101, 000110 and 000111 set `reserved_op` and return rt unchanged. Functions 000000 and 000100 are not affected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and instruction are valid this cycle |
| instr | input | 32 | Instruction word |
| rs_val | input | 64 | Source operand supplying the field bits |
| rt_val | input | 64 | Current destination operand |
| wide_disable | input | 1 | Doubleword variants are not permitted |
| out_valid | output | 1 | Result is valid this cycle |
| reserved_op | output | 1 | Instruction was reserved; result equals the old rt |
| result | output | 64 | Value to write back to rt |

## Verification
On every cycle, the assertions check the one-cycle valid latency, rt passing through for a foreign major opcode, sign extension of the word extract, and rt staying unchanged when a word insert has inverted bounds. How the field is placed for each of the eight variants, the +32 offsets, zero-filling of positions beyond the register, and gating by `wide_disable` are shown only by the bench. It compares every result against a bit-by-bit model, using random fields plus directed corners such as F0=0, F1=31 and inverted bounds.

// File: rtl/bitfield_unit.sv
module bitfield_unit (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [31:0] instr,
  input  logic [63:0] rs_val,
  input  logic [63:0] rt_val,
  input  logic        wide_disable,
  output logic        out_valid,
  output logic        reserved_op,
  output logic [63:0] result
);

  localparam int XLEN = 64;
  localparam int HALF = XLEN / 2;
  localparam logic [5:0] MAJOR = 6'b011111;
  localparam logic [XLEN-1:0] ONES = '1;

  logic [5:0] major, fn;
  logic [4:0] f_hi, f_lo;
  logic       is_ins, is_wide, legal;
  logic       unused_regs;

  assign major       = instr[31:26];
  assign f_hi        = instr[15:11];
  assign f_lo        = instr[10:6];
  assign fn          = instr[5:0];
  assign unused_regs = ^instr[25:16];

  assign is_ins  = fn[2];
  assign is_wide = (fn[1:0] != 2'b00);
  assign legal   = (major == MAJOR) && (fn[5:3] == 3'b000) && !(is_wide && wide_disable);

  // extract path
  logic [6:0]      x_pos, x_wm1;
  logic [XLEN-1:0] x_src, x_raw, x_val;

  assign x_pos = {2'b00, f_lo} + ((fn[1:0] == 2'b10) ? 7'd32 : 7'd0);
  assign x_wm1 = {2'b00, f_hi} + ((fn[1:0] == 2'b01) ? 7'd32 : 7'd0);
  assign x_src = (fn[1:0] == 2'b00) ? {{HALF{1'b0}}, rs_val[HALF-1:0]} : rs_val;
  assign x_raw = (x_src >> x_pos) & (ONES >> (7'd63 - x_wm1));
  assign x_val = (fn[1:0] == 2'b00) ? {{HALF{x_raw[HALF-1]}}, x_raw[HALF-1:0]} : x_raw;

  // insert path
  logic [6:0]      i_lo, i_hi;
  logic            i_ok;
  logic [XLEN-1:0] i_mask, i_raw, i_val;

  assign i_lo   = {2'b00, f_lo} + ((fn[1:0] == 2'b10) ? 7'd32 : 7'd0);
  assign i_hi   = {2'b00, f_hi} + ((fn[1:0] == 2'b01 || fn[1:0] == 2'b10) ? 7'd32 : 7'd0);
  assign i_ok   = (i_lo <= i_hi);
  assign i_mask = (ONES << i_lo) & (ONES >> (7'd63 - i_hi));
  assign i_raw  = rt_val ^ ((rt_val ^ (rs_val << i_lo)) & i_mask);

  always_comb begin
    if (!i_ok)
      i_val = rt_val;
    else if (fn[1:0] == 2'b00)
      i_val = {{HALF{i_raw[HALF-1]}}, i_raw[HALF-1:0]};
    else
      i_val = i_raw;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      reserved_op <= 1'b0;
      result      <= '0;
    end else begin
      out_valid   <= in_valid;
      reserved_op <= in_valid && !legal;
      if (in_valid)
        result <= !legal ? rt_val : (is_ins ? i_val : x_val);
    end
  end

  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid));

  assert_foreign_major_R11: assert property (@(posedge clk) disable iff (rst)
    in_valid && (instr[31:26] != MAJOR) |=> reserved_op && (result == $past(rt_val)));

  assert_word_extract_sext_R3: assert property (@(posedge clk) disable iff (rst)
    in_valid && (instr[31:26] == MAJOR) && (instr[5:0] == 6'd0)
      |=> !reserved_op && (result[63:32] == {32{result[31]}}));

  assert_word_insert_inverted_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid && (instr[31:26] == MAJOR) && (instr[5:0] == 6'd4) && (instr[10:6] > instr[15:11])
      |=> result == $past(rt_val));

endmodule

// File: tb/test_bitfield_unit.sv
module test_bitfield_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] rs_val = '0, rt_val = '0;
  logic        wide_disable = 1'b0;
  logic        out_valid, reserved_op;
  logic [63:0] result;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  bitfield_unit i_bitfield_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .rs_val(rs_val), .rt_val(rt_val), .wide_disable(wide_disable),
    .out_valid(out_valid), .reserved_op(reserved_op), .result(result)
  );

  always #10 clk = ~clk;

  function automatic logic [63:0] ref_ext(logic [63:0] src, int pos, int w);
    logic [63:0] r = '0;
    for (int i = 0; i < 64; i++)
      if (i < w && pos + i < 64) r[i] = src[pos + i];
    return r;
  endfunction

  function automatic logic [63:0] ref_ins(logic [63:0] t, logic [63:0] a, int lo, int hi);
    logic [63:0] r = t;
    for (int i = 0; i < 64; i++)
      if (i >= lo && i <= hi) r[i] = a[i - lo];
    return r;
  endfunction

  function automatic logic [63:0] sx32(logic [63:0] v);
    return {{32{v[31]}}, v[31:0]};
  endfunction

  function automatic logic [64:0] model(logic [31:0] ins, logic [63:0] a, logic [63:0] t, logic wd);
    int f1 = int'(ins[15:11]);
    int f0 = int'(ins[10:6]);
    int fn = int'(ins[5:0]);
    logic [63:0] r;
    if (ins[31:26] != 6'b011111 || fn > 7 || (wd && fn != 0 && fn != 4))
      return {1'b1, t};
    case (fn)
      0: r = sx32(ref_ext({32'd0, a[31:0]}, f0, f1 + 1));
      1: r = ref_ext(a, f0, f1 + 33);
      2: r = ref_ext(a, f0 + 32, f1 + 1);
      3: r = ref_ext(a, f0, f1 + 1);
      4: r = (f0 <= f1) ? sx32(ref_ins(t, a, f0, f1)) : t;
      5: r = ref_ins(t, a, f0, f1 + 32);
      6: r = (f0 <= f1) ? ref_ins(t, a, f0 + 32, f1 + 32) : t;
      default: r = (f0 <= f1) ? ref_ins(t, a, f0, f1) : t;
    endcase
    return {1'b0, r};
  endfunction

  function automatic string tag_of(logic [31:0] ins, logic wd);
    if (ins[31:26] != 6'b011111 || ins[5:3] != 3'b000) return "R11";
    if (wd && ins[1:0] != 2'b00) return "R12";
    case (ins[2:0])
      3'd0: return "R3";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R4";
      3'd4: return "R7";
      3'd5: return "R9";
      3'd6: return "R10";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [31:0] mk(logic [5:0] fn, logic [4:0] f1, logic [4:0] f0);
    return {6'b011111, 10'($urandom), f1, f0, fn};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(logic [31:0] ins, logic [63:0] a, logic [63:0] t, logic wd);
    logic [64:0] e;
    string tg;
    @(negedge clk);
    instr = ins; rs_val = a; rt_val = t; wide_disable = wd; in_valid = 1'b1;
    e = model(ins, a, t, wd);
    tg = tag_of(ins, wd);
    @(posedge clk); #2;
    check({tg, " result"}, result, e[63:0]);
    check({tg, " reserved"}, {63'd0, reserved_op}, {63'd0, e[64]});
    check("R1 valid", {63'd0, out_valid}, 64'd1);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] r1, r2;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset valid", {63'd0, out_valid}, 64'd0);
    check("R1 reset reserved", {63'd0, reserved_op}, 64'd0);
    @(negedge clk); rst = 1'b0;

    // directed corners
    run_op(mk(6'd0, 5'd31, 5'd0), 64'h0123_4567_89ab_cdef, 64'h0, 1'b0);
    run_op(mk(6'd0, 5'd7, 5'd28), 64'hffff_ffff_ffff_ffff, 64'h0, 1'b0);
    run_op(mk(6'd3, 5'd31, 5'd0), 64'hfedc_ba98_7654_3210, 64'h0, 1'b0);
    run_op(mk(6'd1, 5'd31, 5'd0), 64'hfedc_ba98_7654_3210, 64'h0, 1'b0);
    run_op(mk(6'd1, 5'd31, 5'd31), 64'hffff_ffff_ffff_ffff, 64'h0, 1'b0);
    run_op(mk(6'd2, 5'd31, 5'd31), 64'hffff_ffff_ffff_ffff, 64'h0, 1'b0);
    run_op(mk(6'd4, 5'd31, 5'd0), 64'h0000_0000_8000_0001, 64'h1234_5678_0000_0000, 1'b0);
    run_op(mk(6'd4, 5'd3, 5'd9), 64'hffff_ffff_ffff_ffff, 64'h1234_5678_0000_0000, 1'b0);
    run_op(mk(6'd7, 5'd3, 5'd9), 64'hffff_ffff_ffff_ffff, 64'haaaa_5555_aaaa_5555, 1'b0);
    run_op(mk(6'd7, 5'd0, 5'd0), 64'h1, 64'h0, 1'b0);
    run_op(mk(6'd6, 5'd2, 5'd5), 64'hffff_ffff_ffff_ffff, 64'h0, 1'b0);
    run_op(mk(6'd6, 5'd31, 5'd0), 64'h1234_5678_9abc_def0, 64'h0, 1'b0);
    run_op(mk(6'd5, 5'd0, 5'd31), 64'h3, 64'h0, 1'b0);
    run_op(mk(6'd5, 5'd31, 5'd0), 64'hcafe_f00d_dead_beef, 64'h0, 1'b0);
    run_op(mk(6'd8, 5'd4, 5'd2), 64'h55, 64'h77, 1'b0);
    run_op(mk(6'd63, 5'd4, 5'd2), 64'h55, 64'h77, 1'b0);
    run_op({6'b000000, 20'h12345, 6'd3}, 64'h55, 64'h99, 1'b0);
    run_op(mk(6'd3, 5'd7, 5'd0), 64'hff, 64'h1234, 1'b1);
    run_op(mk(6'd0, 5'd7, 5'd0), 64'h80, 64'h1234, 1'b1);
    run_op(mk(6'd4, 5'd7, 5'd0), 64'h80, 64'h1234, 1'b1);

    // R1: valid drops the cycle after in_valid drops
    @(posedge clk); #2;
    check("R1 idle valid", {63'd0, out_valid}, 64'd0);

    // R2: register fields of the instruction do not matter
    @(negedge clk);
    instr = {6'b011111, 10'h000, 5'd9, 5'd3, 6'd7}; rs_val = 64'h1234_abcd; rt_val = 64'hf0f0;
    wide_disable = 1'b0; in_valid = 1'b1;
    @(posedge clk); #2; r1 = result;
    @(negedge clk); instr[25:16] = 10'h3ff;
    @(posedge clk); #2; r2 = result;
    check("R2 reg fields ignored", r2, r1);
    in_valid = 1'b0;

    // random per function, with and without wide_disable
    for (int f = 0; f < 8; f++)
      for (int k = 0; k < 150; k++)
        run_op(mk(6'(f), 5'($urandom), 5'($urandom)),
               {$urandom, $urandom}, {$urandom, $urandom}, 1'b0);
    for (int k = 0; k < 200; k++)
      run_op(mk(6'($urandom), 5'($urandom), 5'($urandom)),
             {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));

    @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule